// File: doc/BRIEF.md
# Jumper-Selected Baud Tap Divider

This block produces the bit-rate reference for a serial card that sits behind a parallel port. Two slow source clocks arrive as plain input lines: one runs at a multiple of 110 Hz and the other at a multiple of 300 Hz. A static board jumper chooses which of them feeds a seven-stage binary divider. The divider advances on each falling edge of the chosen source. Both source lines are synchronised to the system clock before their edges are detected.

Software writes a control byte. One bit of that byte holds the divider cleared. Another bit chooses whether the divide-by-16 tap or the divide-by-32 tap of the count is returned. The chosen tap is presented on the top bit of a status byte, which software polls to time serial bits. Changing the jumper while the divider is counting need not be glitch-free.

Top module: `baud_tap_div`

## Requirements
- R1: After system reset the control register is all zeros, the divider count is zero, and the status byte reads 0x00.
- R2: When `jumper_i` is 1, each falling edge of `src_slow_i` advances the count by one, and edges on `src_fast_i` have no effect.
- R3: When `jumper_i` is 0, each falling edge of `src_fast_i` advances the count by one, and edges on `src_slow_i` have no effect.
- R4: A rising edge of the selected source leaves the count unchanged.
- R5: When the select bit is 0, status bit 7 equals count bit 3, so it toggles once every 8 falling edges (divide by 16).
- R6: When the select bit is 1, status bit 7 equals count bit 4, so it toggles once every 16 falling edges (divide by 32).
- R7: A write with `ctrl_we_i` high loads the control register. Data bit 2 is the tap select and data bit 0 is the divider clear. All other data bits have no effect.
- R8: While the clear bit is 1 the count is zero, status bit 7 reads 0, and source edges are ignored. After the bit is cleared, counting resumes from zero.
- R9: The count wraps from 127 to 0, so after 128 falling edges from zero the status is the same as at zero.
- R10: Status bits 6 to 0 always read 0.
- R11: A falling edge on the selected source line reaches the status byte on the third rising edge of `clk` after the edge, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| src_slow_i | input | 1 | 110-rate source clock line (asynchronous) |
| src_fast_i | input | 1 | 300-rate source clock line (asynchronous) |
| jumper_i | input | 1 | Static source-choice jumper: 1 selects the slow source |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control write data: bit 0 clears the divider, bit 2 selects the divide-by-32 tap |
| status_o | output | 8 | Status byte: bit 7 is the selected tap, all other bits read 0 |

## Verification
The divider is driven with long runs of falling edges on the active source, first with the divide-by-16 tap and then with the divide-by-32 tap. These runs tell the two tap positions apart and confirm the toggle period of each. Edges on the inactive source, and rising edges on their own, are interleaved to show that only falling edges of the jumper-chosen line count; swapping the jumper exposes a reversed source mux. Writes with every unrelated control bit set, a hold-and-release sequence, a full 128-edge wrap and one edge timed to the clock cycle separate the clear behaviour, the bit decoding, the wrap and the synchroniser latency.

// File: rtl/baud_tap_pkg.sv
package baud_tap_pkg;
    localparam int CTRL_W        = 8;
    localparam int STATUS_W      = 8;
    localparam int CTRL_HOLD_BIT = 0;
    localparam int CTRL_SEL_BIT  = 2;
    localparam int STATUS_TAP_BIT = 7;
    localparam int NUM_SRC       = 2;
    // source index: 0 = fast (300-rate), 1 = slow (110-rate)
    localparam int SRC_FAST      = 0;
    localparam int SRC_SLOW      = 1;

    typedef struct packed {
        logic sel_wide;  // 1: divide-by-32 tap, 0: divide-by-16 tap
        logic hold;      // 1: divider held at zero
    } ctrl_t;
endpackage

// File: rtl/btd_src_sync.sv
module btd_src_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic fall_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] pipe;
        logic                   prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pipe = {st_q.pipe[SYNC_STAGES-2:0], line_i};
        st_d.prev = st_q.pipe[SYNC_STAGES-1];
        fall_o    = st_q.prev & ~st_q.pipe[SYNC_STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R11: a detected fall lasts exactly one system clock
    single_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);
endmodule

// File: rtl/btd_ctrl_reg.sv
module btd_ctrl_reg
    import baud_tap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [CTRL_W-1:0] wdata_i,
    output ctrl_t             ctrl_o
);
    ctrl_t ctrl_d, ctrl_q;
    logic  unused_wdata;

    assign unused_wdata = ^wdata_i;

    always_comb begin
        ctrl_d = ctrl_q;
        if (we_i) begin
            ctrl_d.sel_wide = wdata_i[CTRL_SEL_BIT];
            ctrl_d.hold     = wdata_i[CTRL_HOLD_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign ctrl_o = ctrl_q;

    // R7
    sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (ctrl_o.sel_wide == $past(wdata_i[CTRL_SEL_BIT])));
    // R7
    ctrl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(ctrl_o));
endmodule

// File: rtl/btd_divider.sv
module btd_divider #(
    parameter int STAGES = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              hold_i,
    output logic [STAGES-1:0] count_o
);
    typedef struct packed {
        logic [STAGES-1:0] count;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hold_i)      st_d.count = '0;
        else if (step_i) st_d.count = st_q.count + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.count;

    // R8
    hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> (count_o == '0));
    // R9
    step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !hold_i) |=> (count_o == STAGES'($past(count_o) + 1'b1)));
    // R4
    idle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !hold_i) |=> $stable(count_o));
endmodule

// File: rtl/baud_tap_div.sv
module baud_tap_div
    import baud_tap_pkg::*;
#(
    parameter int STAGES      = 7,
    parameter int SYNC_STAGES = 2,
    parameter int TAP_NARROW  = 3,
    parameter int TAP_WIDE    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                src_slow_i,
    input  logic                src_fast_i,
    input  logic                jumper_i,
    input  logic                ctrl_we_i,
    input  logic [CTRL_W-1:0]   ctrl_wdata_i,
    output logic [STATUS_W-1:0] status_o
);
    logic [NUM_SRC-1:0] src_lines;
    logic [NUM_SRC-1:0] src_fall;
    ctrl_t              ctrl;
    logic               step;
    logic [STAGES-1:0]  count;
    logic               tap;
    logic               unused_count;

    assign src_lines[SRC_FAST] = src_fast_i;
    assign src_lines[SRC_SLOW] = src_slow_i;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        btd_src_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .line_i(src_lines[i]),
            .fall_o(src_fall[i])
        );
    end

    assign step = jumper_i ? src_fall[SRC_SLOW] : src_fall[SRC_FAST];

    btd_ctrl_reg u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (ctrl_we_i),
        .wdata_i(ctrl_wdata_i),
        .ctrl_o (ctrl)
    );

    btd_divider #(.STAGES(STAGES)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (step),
        .hold_i (ctrl.hold),
        .count_o(count)
    );

    assign unused_count = ^count;
    assign tap          = ctrl.sel_wide ? count[TAP_WIDE] : count[TAP_NARROW];

    always_comb begin
        status_o                 = '0;
        status_o[STATUS_TAP_BIT] = tap;
    end

    // R8
    held_tap_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctrl.hold) && ctrl.hold |-> !status_o[STATUS_TAP_BIT]);
endmodule

// File: tb/tb_baud_tap_div.sv
module tb_baud_tap_div;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       src_slow = 1'b0;
    logic       src_fast = 1'b0;
    logic       jumper = 1'b1;
    logic       ctrl_we = 1'b0;
    logic [7:0] ctrl_wdata = 8'h00;
    logic [7:0] status;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int cnt = 0;
    bit sel_m = 0;
    bit hold_m = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    baud_tap_div dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_slow_i  (src_slow),
        .src_fast_i  (src_fast),
        .jumper_i    (jumper),
        .ctrl_we_i   (ctrl_we),
        .ctrl_wdata_i(ctrl_wdata),
        .status_o    (status)
    );

    function automatic logic [7:0] model_status();
        bit t;
        t = sel_m ? bit'((cnt >> 4) & 1) : bit'((cnt >> 3) & 1);
        return {t, 7'b0};
    endfunction

    // monitor: compares pushed expectations at the falling clock edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [7:0] e;
            string      r;
            e = exp_q.pop_front();
            r = tag_q.pop_front();
            checks++;
            if (status !== e) begin
                errors++;
                $display("FAIL %s: status actual 0x%02h expected 0x%02h", r, status, e);
            end
        end
    end

    task automatic push_exp(input logic [7:0] e, input string r);
        exp_q.push_back(e);
        tag_q.push_back(r);
    endtask

    task automatic expect_model(input string r);
        @(posedge clk); #1;
        push_exp(model_status(), r);
        @(negedge clk); #1;
    endtask

    // one full pulse on a source line; which=1 slow, 0 fast
    task automatic pulse_src(input bit which, input string r);
        @(negedge clk);
        if (which) src_slow = 1'b1; else src_fast = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        if (which) src_slow = 1'b0; else src_fast = 1'b0;
        repeat (4) @(posedge clk);
        if (!hold_m && (which == jumper)) cnt = (cnt + 1) % 128;
        expect_model(r);
    endtask

    task automatic write_ctrl(input logic [7:0] v);
        @(negedge clk);
        ctrl_we = 1'b1;
        ctrl_wdata = v;
        @(negedge clk);
        ctrl_we = 1'b0;
        ctrl_wdata = 8'h00;
        sel_m = v[2];
        hold_m = v[0];
        if (hold_m) cnt = 0;
        repeat (2) @(posedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        expect_model("R1");

        // R2 / R5: slow source, divide-by-16 tap
        jumper = 1'b1;
        for (int i = 0; i < 20; i++) pulse_src(1'b1, "R5");
        // R2: fast source ignored under jumper=1
        for (int i = 0; i < 6; i++) pulse_src(1'b0, "R2");

        // R4: rising edge alone does not advance
        write_ctrl(8'h01);
        write_ctrl(8'h00);
        for (int i = 0; i < 7; i++) pulse_src(1'b1, "R4");
        @(negedge clk); src_slow = 1'b1;
        repeat (6) @(posedge clk);
        expect_model("R4");
        @(negedge clk); src_slow = 1'b0;
        repeat (4) @(posedge clk);
        cnt = (cnt + 1) % 128;
        expect_model("R4");

        // R6: divide-by-32 tap
        write_ctrl(8'h05);
        write_ctrl(8'h04);
        for (int i = 0; i < 34; i++) pulse_src(1'b1, "R6");

        // R3: jumper=0, slow ignored, fast counts
        jumper = 1'b0;
        for (int i = 0; i < 5; i++) pulse_src(1'b1, "R3");
        for (int i = 0; i < 20; i++) pulse_src(1'b0, "R3");

        // R7: unrelated bits set; select=0, clear=0
        write_ctrl(8'hFA);
        expect_model("R7");
        for (int i = 0; i < 10; i++) pulse_src(1'b0, "R7");

        // R8: hold clears, ignores edges, resumes from zero
        write_ctrl(8'h01);
        expect_model("R8");
        for (int i = 0; i < 10; i++) pulse_src(1'b0, "R8");
        write_ctrl(8'h00);
        for (int i = 0; i < 9; i++) pulse_src(1'b0, "R8");

        // R9: wrap after 128 edges
        write_ctrl(8'h01);
        write_ctrl(8'h00);
        for (int i = 0; i < 136; i++) pulse_src(1'b0, "R9");

        // R10: low status bits always zero
        @(posedge clk); #1;
        checks++;
        if ((status & 8'h7F) !== 8'h00) begin
            errors++;
            $display("FAIL R10: low bits actual 0x%02h expected 0x00", status & 8'h7F);
        end

        // R11: latency from a fall to the status byte (count 7 -> 8, sel=0)
        write_ctrl(8'h01);
        write_ctrl(8'h00);
        for (int i = 0; i < 7; i++) pulse_src(1'b0, "R11");
        @(negedge clk); src_fast = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk); src_fast = 1'b0;
        @(posedge clk);
        @(posedge clk); #1;
        push_exp(8'h00, "R11");
        @(posedge clk); #1;
        push_exp(8'h80, "R11");
        @(negedge clk); #1;
        cnt = 8;
        expect_model("R11");

        repeat (4) @(posedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule